// File: doc/BRIEF.md
# Driver Operation Mode Controller

This block is the mode sequencer of a multi-channel output driver. It holds one of four operating modes: Sleep, Idle, Active and Limp Home. It moves between them based on an active-low sleep pin, the per-channel input pins, and two register-file sources: the per-channel enable bits and an activate bit. From the current mode and two undervoltage flags, one for the logic supply and one for the motor supply, it derives four things. These are the gated drive command for every channel, a reset for the register file, an indication that the serial interface is usable, and a write-protect flag for the register file.

A request to switch a channel on can arrive while the driver is unpowered, that is, in Sleep or Idle. The block then waits a parameterized number of clock edges before it enters the powered mode. All outputs stay off during that wait. Changes between powered modes, and changes into an unpowered mode, take effect on the next edge. The register file, the serial shifter and the analog comparators lie outside the block and connect to its ports.

Top module: `drv_mode_ctrl`

## Requirements
- R1: Reset puts the block in Sleep (mode code 00). While in Sleep, every drive bit is 0, reg_reset is 1, spi_avail is 0 and reg_wprot is 0. This holds whatever the supply flags, the enable bits and the activate bit are. With sleep_n low and no input pin high, the block stays in Sleep.
- R2: From Sleep, sleep_n high with no input pin high moves the block to Idle (code 01) on the next edge. From Idle, sleep_n low with no input pin high moves it to Sleep on the next edge.
- R3: In Idle every drive bit is 0 and reg_wprot is 0. spi_avail equals the inverse of vdd_uv, and reg_reset equals vdd_uv.
- R4: In Sleep or Idle, a wake request moves the block to its target on the TRANS_CYCLES-th consecutive clock edge at which the same request is present. The target is Active (code 10) when sleep_n is high, and Limp Home (code 11) when sleep_n is low and an input pin is high. A wake request is any input pin high, or, while reg_reset is 0, the activate bit or any enable bit. Until the move, all drive bits stay 0.
- R5: If a pending wake request disappears or changes its target before the delay has elapsed, the delay count starts again from zero.
- R6: In Active with vdd_uv low, drive[i] is in_pin[i] OR en_bit[i], whatever vm_uv is. In this state spi_avail is 1, reg_reset is 0 and reg_wprot is 0.
- R7: In Active with vdd_uv high and vm_uv low, drive equals in_pin and the enable bits have no effect. In this state spi_avail is 0 and reg_reset is 1.
- R8: In Active or Limp Home with both vdd_uv and vm_uv high, every drive bit is 0.
- R9: In Limp Home, drive follows in_pin only and the enable bits have no effect (unless R8 applies). reg_wprot and spi_avail both equal the inverse of vdd_uv, and reg_reset equals vdd_uv.
- R10: In Active with sleep_n high, the block stays in Active while a wake request is present and otherwise moves to Idle on the next edge. In Active with sleep_n low, it moves on the next edge to Limp Home if any input pin is high, and to Sleep if none is.
- R11: In Limp Home with sleep_n low and no input pin high, the block moves to Sleep on the next edge. In Limp Home with sleep_n high, it moves on the next edge to Active if a wake request is present and to Idle if none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low sleep pin level |
| in_pin | input | NUM_CH | Channel input pin levels |
| en_bit | input | NUM_CH | Channel enable bits from the register file |
| act_bit | input | 1 | Activate bit from the register file |
| vdd_uv | input | 1 | Logic supply undervoltage flag |
| vm_uv | input | 1 | Motor supply undervoltage flag |
| mode | output | 2 | Current mode: 00 Sleep, 01 Idle, 10 Active, 11 Limp Home |
| drive | output | NUM_CH | Gated per-channel drive commands |
| reg_reset | output | 1 | Hold the register file in reset |
| spi_avail | output | 1 | Serial interface usable |
| reg_wprot | output | 1 | Register writes ignored (read-only access) |

## Verification
The gating is tried in Active with a table of patterns. In these patterns the input pins and the enable bits select disjoint and overlapping channels, and each of the four supply-flag combinations is applied. Together they separate the OR of both sources, pins-only gating and full blanking. The same pin and enable patterns are then repeated in Limp Home, which shows that the enable bits are excluded there and that write protection follows the logic supply. The wake sequences are tried from Sleep and from Idle, through the pins with sleep_n low and high and through the activate bit. A request is also dropped partway through the wait. These sequences show the exact edge of arrival, the restart of the count, and that the request is ignored while the registers are held in reset.

// File: rtl/drv_mode_pkg.sv
package drv_mode_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP  = 2'b00,
      MODE_IDLE   = 2'b01,
      MODE_ACTIVE = 2'b10,
      MODE_LIMP   = 2'b11
   } mode_t;

   function automatic logic is_powered(input mode_t m);
      return (m == MODE_ACTIVE) || (m == MODE_LIMP);
   endfunction

endpackage

// File: rtl/drv_mode_fsm.sv
module drv_mode_fsm
   import drv_mode_pkg::*;
#(
   parameter int TRANS_CYCLES = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sleep_n,
   input  logic  any_in,
   input  logic  wake_req,
   output mode_t mode_q
);

   mode_t tgt;
   logic  delayed;

   // One target rule serves every mode; only the timing of the move differs.
   always_comb begin
      if (!sleep_n) tgt = any_in ? MODE_LIMP : MODE_SLEEP;
      else          tgt = wake_req ? MODE_ACTIVE : MODE_IDLE;
      delayed = !is_powered(mode_q) && is_powered(tgt);
   end

   if (TRANS_CYCLES < 0) begin : g_bad_delay
      $error("TRANS_CYCLES must not be negative");
   end

   if (TRANS_CYCLES == 0) begin : g_no_timer
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mode_q <= MODE_SLEEP;
         else        mode_q <= tgt;
      end
   end else begin : g_timer
      localparam int CW = (TRANS_CYCLES < 2) ? 1 : $clog2(TRANS_CYCLES + 1);
      localparam logic [CW-1:0] LAST = CW'(TRANS_CYCLES - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] hit;
      logic          pend_vld_q;
      mode_t         pend_q;

      assign hit = (pend_vld_q && (pend_q == tgt)) ? cnt_q : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q     <= MODE_SLEEP;
            pend_q     <= MODE_SLEEP;
            pend_vld_q <= 1'b0;
            cnt_q      <= '0;
         end else if (delayed) begin
            if (hit == LAST) begin
               mode_q     <= tgt;
               pend_vld_q <= 1'b0;
               cnt_q      <= '0;
            end else begin
               pend_q     <= tgt;
               pend_vld_q <= 1'b1;
               cnt_q      <= hit + 1'b1;
            end
         end else begin
            mode_q     <= tgt;
            pend_vld_q <= 1'b0;
            cnt_q      <= '0;
         end
      end
   end

endmodule

// File: rtl/drv_mode_policy.sv
module drv_mode_policy
   import drv_mode_pkg::*;
(
   input  mode_t mode_q,
   input  logic  vdd_uv,
   input  logic  vm_uv,
   output logic  reg_reset,
   output logic  spi_avail,
   output logic  reg_wprot,
   output logic  pin_ok,
   output logic  en_ok
);

   always_comb begin
      reg_reset = vdd_uv;
      spi_avail = !vdd_uv;
      reg_wprot = 1'b0;
      pin_ok    = 1'b0;
      en_ok     = 1'b0;
      unique case (mode_q)
         MODE_SLEEP: begin
            reg_reset = 1'b1;
            spi_avail = 1'b0;
         end
         MODE_IDLE: ;
         MODE_ACTIVE: begin
            pin_ok = !(vdd_uv && vm_uv);
            en_ok  = !vdd_uv;
         end
         MODE_LIMP: begin
            pin_ok    = !(vdd_uv && vm_uv);
            reg_wprot = !vdd_uv;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/drv_mode_gate.sv
module drv_mode_gate #(
   parameter int NUM_CH = 8
) (
   input  logic [NUM_CH-1:0] in_pin,
   input  logic [NUM_CH-1:0] en_bit,
   input  logic              pin_ok,
   input  logic              en_ok,
   output logic [NUM_CH-1:0] drive
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign drive[i] = (in_pin[i] & pin_ok) | (en_bit[i] & en_ok);
   end

endmodule

// File: rtl/drv_mode_ctrl.sv
module drv_mode_ctrl
   import drv_mode_pkg::*;
#(
   parameter int NUM_CH       = 8,
   parameter int TRANS_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_n,
   input  logic [NUM_CH-1:0] in_pin,
   input  logic [NUM_CH-1:0] en_bit,
   input  logic              act_bit,
   input  logic              vdd_uv,
   input  logic              vm_uv,
   output logic [1:0]        mode,
   output logic [NUM_CH-1:0] drive,
   output logic              reg_reset,
   output logic              spi_avail,
   output logic              reg_wprot
);

   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_width
      $error("NUM_CH must lie between 1 and 64");
   end

   mode_t mode_q;
   logic  any_in;
   logic  wake_req;
   logic  pin_ok;
   logic  en_ok;

   // Register-file sources count only while the registers are out of reset.
   assign any_in   = |in_pin;
   assign wake_req = any_in | ((act_bit | (|en_bit)) & ~reg_reset);

   drv_mode_fsm #(.TRANS_CYCLES(TRANS_CYCLES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep_n  (sleep_n),
      .any_in   (any_in),
      .wake_req (wake_req),
      .mode_q   (mode_q)
   );

   drv_mode_policy u_policy (
      .mode_q    (mode_q),
      .vdd_uv    (vdd_uv),
      .vm_uv     (vm_uv),
      .reg_reset (reg_reset),
      .spi_avail (spi_avail),
      .reg_wprot (reg_wprot),
      .pin_ok    (pin_ok),
      .en_ok     (en_ok)
   );

   drv_mode_gate #(.NUM_CH(NUM_CH)) u_gate (
      .in_pin (in_pin),
      .en_bit (en_bit),
      .pin_ok (pin_ok),
      .en_ok  (en_ok),
      .drive  (drive)
   );

   assign mode = mode_q;

endmodule

// File: rtl/drv_mode_chk.sv
module drv_mode_chk
   import drv_mode_pkg::*;
#(
   parameter int NUM_CH       = 8,
   parameter int TRANS_CYCLES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] in_pin,
   input logic              vdd_uv,
   input logic              vm_uv,
   input logic [1:0]        mode,
   input logic [NUM_CH-1:0] drive,
   input logic              reg_reset,
   input logic              spi_avail,
   input logic              reg_wprot
);

   localparam int HW = $clog2(TRANS_CYCLES + 2);
   localparam logic [HW-1:0] HMAX = HW'(TRANS_CYCLES);

   logic [1:0]    prev_q;
   logic [HW-1:0] held_q;

   // Counts the edges across which the mode has stayed unchanged, saturating at the delay.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 2'b00;
         held_q <= '0;
      end else begin
         prev_q <= mode;
         if (mode != prev_q)    held_q <= HW'(1);
         else if (held_q < HMAX) held_q <= held_q + 1'b1;
      end
   end

   // R1
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> (drive == '0 && reg_reset && !spi_avail && !reg_wprot));

   // R3
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> (drive == '0 && !reg_wprot));

   // R4
   wake_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != prev_q && mode[1] && !prev_q[1]) |-> (held_q >= HMAX));

   // R8
   dual_uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vdd_uv && vm_uv) |-> (drive == '0));

   // R9
   limp_pins_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |-> ((drive & ~in_pin) == '0));

   // R9
   wprot_limp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wprot |-> (mode == 2'b11 && spi_avail));

endmodule

bind drv_mode_ctrl drv_mode_chk #(.NUM_CH(NUM_CH), .TRANS_CYCLES(TRANS_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_pin    (in_pin),
   .vdd_uv    (vdd_uv),
   .vm_uv     (vm_uv),
   .mode      (mode),
   .drive     (drive),
   .reg_reset (reg_reset),
   .spi_avail (spi_avail),
   .reg_wprot (reg_wprot)
);

// File: tb/test_drv_mode_ctrl.sv
`timescale 1ns/100ps
module test_drv_mode_ctrl;

   localparam int NCH = 4;
   localparam int DLY = 4;
   localparam int NV  = 8;

   // {vdd_uv, vm_uv, in[3:0], en[3:0], drive[3:0], spi, rst, wprot}
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 1'b0, 4'b0011, 4'b0101, 4'b0111, 1'b1, 1'b0, 1'b0},  // R6
      {1'b0, 1'b1, 4'b0011, 4'b0101, 4'b0111, 1'b1, 1'b0, 1'b0},  // R6
      {1'b1, 1'b0, 4'b0011, 4'b0101, 4'b0011, 1'b0, 1'b1, 1'b0},  // R7
      {1'b1, 1'b1, 4'b0011, 4'b0101, 4'b0000, 1'b0, 1'b1, 1'b0},  // R8
      {1'b0, 1'b0, 4'b0000, 4'b1000, 4'b1000, 1'b1, 1'b0, 1'b0},  // R6
      {1'b0, 1'b0, 4'b1000, 4'b0000, 4'b1000, 1'b1, 1'b0, 1'b0},  // R6
      {1'b1, 1'b0, 4'b0000, 4'b1111, 4'b0000, 1'b0, 1'b1, 1'b0},  // R7
      {1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0}   // R6
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sleep_n = 1'b0;
   logic [NCH-1:0] in_pin = '0;
   logic [NCH-1:0] en_bit = '0;
   logic           act_bit = 1'b0;
   logic           vdd_uv = 1'b0;
   logic           vm_uv = 1'b0;
   logic [1:0]     mode;
   logic [NCH-1:0] drive;
   logic           reg_reset, spi_avail, reg_wprot;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   drv_mode_ctrl #(.NUM_CH(NCH), .TRANS_CYCLES(DLY)) i_drv_mode_ctrl (
      .clk (clk), .rst_n (rst_n), .sleep_n (sleep_n), .in_pin (in_pin),
      .en_bit (en_bit), .act_bit (act_bit), .vdd_uv (vdd_uv), .vm_uv (vm_uv),
      .mode (mode), .drive (drive), .reg_reset (reg_reset),
      .spi_avail (spi_avail), .reg_wprot (reg_wprot)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk_side(input string tag, input logic s, input logic r, input logic w);
      chk({tag, " spi_avail"}, 32'(spi_avail), 32'(s));
      chk({tag, " reg_reset"}, 32'(reg_reset), 32'(r));
      chk({tag, " reg_wprot"}, 32'(reg_wprot), 32'(w));
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      tick(2);
      // R1 reset state
      chk("R1 mode", 32'(mode), 32'h0);
      chk("R1 drive", 32'(drive), 32'h0);
      chk_side("R1", 1'b0, 1'b1, 1'b0);
      rst_n = 1'b1;
      en_bit = 4'hF; act_bit = 1'b1;
      tick(5);
      chk("R1 sleep holds", 32'(mode), 32'h0);
      chk("R1 drive off", 32'(drive), 32'h0);

      // R2 Sleep -> Idle
      en_bit = '0; act_bit = 1'b0; sleep_n = 1'b1;
      tick();
      chk("R2 to idle", 32'(mode), 32'h1);
      chk_side("R3", 1'b1, 1'b0, 1'b0);
      vdd_uv = 1'b1; act_bit = 1'b1;
      #0.5;
      chk_side("R3 uv", 1'b0, 1'b1, 1'b0);
      tick(6);
      chk("R4 act ignored in reset", 32'(mode), 32'h1);
      chk("R3 drive off", 32'(drive), 32'h0);
      vdd_uv = 1'b0;

      // R4 Idle -> Active by activate bit (still set)
      tick(DLY - 1);
      chk("R4 still idle", 32'(mode), 32'h1);
      chk("R4 drive off while waiting", 32'(drive), 32'h0);
      tick();
      chk("R4 active", 32'(mode), 32'h2);

      // R10 back to Idle, then R5 restart
      act_bit = 1'b0;
      tick();
      chk("R10 to idle", 32'(mode), 32'h1);
      act_bit = 1'b1;
      tick(2);
      act_bit = 1'b0;
      tick();
      chk("R5 dropped", 32'(mode), 32'h1);
      act_bit = 1'b1;
      tick(DLY - 1);
      chk("R5 restarted", 32'(mode), 32'h1);
      tick();
      chk("R5 active", 32'(mode), 32'h2);

      // Gating table in Active (R6 R7 R8)
      for (int v = 0; v < NV; v++) begin
         vdd_uv = VEC[v][16]; vm_uv = VEC[v][15];
         in_pin = VEC[v][14:11]; en_bit = VEC[v][10:7];
         #0.5;
         chk($sformatf("R6/R7/R8 row %0d drive", v), 32'(drive), 32'(VEC[v][6:3]));
         chk_side($sformatf("R6/R7 row %0d", v), VEC[v][2], VEC[v][1], VEC[v][0]);
         vdd_uv = 1'b0; vm_uv = 1'b0; in_pin = '0; en_bit = '0;
         tick();
      end
      chk("R10 active kept", 32'(mode), 32'h2);

      // R10 pin keeps Active, then Idle
      act_bit = 1'b0; in_pin = 4'b0100;
      tick();
      chk("R10 pin holds active", 32'(mode), 32'h2);
      in_pin = '0;
      tick();
      chk("R10 idle", 32'(mode), 32'h1);

      // Active -> Limp
      act_bit = 1'b1;
      tick(DLY);
      chk("R4 active again", 32'(mode), 32'h2);
      act_bit = 1'b0; sleep_n = 1'b0; in_pin = 4'b0010; en_bit = 4'b1001;
      tick();
      chk("R10 to limp", 32'(mode), 32'h3);
      chk("R9 drive pins only", 32'(drive), 32'h2);
      chk_side("R9", 1'b1, 1'b0, 1'b1);
      vdd_uv = 1'b1;
      #0.5;
      chk("R9 uv drive", 32'(drive), 32'h2);
      chk_side("R9 uv", 1'b0, 1'b1, 1'b0);
      vm_uv = 1'b1;
      #0.5;
      chk("R8 limp blank", 32'(drive), 32'h0);
      vdd_uv = 1'b0; vm_uv = 1'b0; en_bit = '0;

      // R11 Limp -> Sleep
      in_pin = '0;
      tick();
      chk("R11 to sleep", 32'(mode), 32'h0);

      // R4 Sleep -> Limp by pin
      in_pin = 4'b1000;
      tick(DLY - 1);
      chk("R4 sleep waiting", 32'(mode), 32'h0);
      chk("R4 drive off", 32'(drive), 32'h0);
      tick();
      chk("R4 to limp", 32'(mode), 32'h3);
      chk("R9 limp drive", 32'(drive), 32'h8);

      // R11 Limp -> Active, R10 back, R11 -> Idle
      sleep_n = 1'b1;
      tick();
      chk("R11 limp to active", 32'(mode), 32'h2);
      chk("R6 drive", 32'(drive), 32'h8);
      sleep_n = 1'b0;
      tick();
      chk("R10 active to limp", 32'(mode), 32'h3);
      sleep_n = 1'b1; in_pin = '0;
      tick();
      chk("R11 limp to idle", 32'(mode), 32'h1);

      // R2 Idle -> Sleep, R4 Sleep -> Active by pin
      sleep_n = 1'b0;
      tick();
      chk("R2 idle to sleep", 32'(mode), 32'h0);
      sleep_n = 1'b1; in_pin = 4'b0001;
      tick(DLY - 1);
      chk("R4 sleep waiting active", 32'(mode), 32'h0);
      tick();
      chk("R4 sleep to active", 32'(mode), 32'h2);
      chk("R6 drive pin", 32'(drive), 32'h1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule